// File: doc/BRIEF.md
# Programmable Frequency Generator Bank

This block holds six programmable frequency generators. Each one picks one of three reference tick streams and divides it by a programmed ratio. The three streams are a CPU tick, an auxiliary tick and a second auxiliary tick. Each input tick is a single-cycle enable in the system clock domain. For its own output, a generator gives a one-cycle strobe each time its count completes. It also drives a level that inverts on every strobe, so that level is a clock-like waveform at half the strobe rate. The configuration sits in two 32-bit registers, three generators to a register, and is reached over a plain word-wide read/write port.

A parameter fixes the field layout at build time. In the legacy layout each generator has a source bit and an enable bit, and it always divides by an even ratio. In the extended layout a two-bit source code replaces both, with code zero meaning "off". A per-register scale bit also switches that register's three generators between even-only and unit-step division. Divider settings are shadowed. A new ratio or source takes hold only when the running count ends, so a reconfiguration never shortens an output period.

Top module: `fgen_bank`

## Requirements
- R1: After reset both registers read zero, every strobe and every toggle output is low, and all generators are off in both layouts.
- R2: A write with `bus_wr` high stores `bus_wdata` into the register chosen by `bus_addr` at the next clock edge. `bus_rdata` always shows the register chosen by `bus_addr`, and the other register is left unchanged.
- R3: Generator g uses register g/3, in the 10-bit field that starts at bit 10*(g mod 3). In that field, bits 1:0 are the source/enable code and bits 9:2 are the divider code N.
- R4: Legacy layout: code bit 1 enables the generator and code bit 0 picks the source (0 = CPU tick, 1 = auxiliary tick). The generator strobes once per 2*(N+1) ticks of that source.
- R5: Extended layout: code 0 turns the generator off, code 1 picks the second auxiliary tick, code 2 picks the CPU tick and code 3 picks the auxiliary tick.
- R6: Extended layout: bit 30 of a register is shared by its three generators. When it is set the ratio is N+1; when it is clear the ratio is 2*(N+1). In the legacy layout bit 30 has no effect on the ratio.
- R7: With a ratio of 1, each selected tick yields a strobe in the cycle directly after it. Strobes last exactly one cycle.
- R8: While a generator is off, its strobe and toggle outputs stay low and its count is cleared. After it is switched back on, its first strobe needs a full ratio of ticks.
- R9: A new divider code or source written to a running generator takes effect only after the current count reaches its end. The period in progress completes with the old ratio.
- R10: A generator's toggle output inverts on each of its strobes and holds its value otherwise.
- R11: A register write reaches the generators one cycle after it lands in the register. A tick in the cycle directly after the write edge is still handled with the previous setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the configuration registers |
| bus_addr | input | 1 | Register select for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| tick_cpu | input | 1 | CPU reference tick, one-cycle enable |
| tick_aux | input | 1 | Auxiliary reference tick, one-cycle enable |
| tick_aux2 | input | 1 | Second auxiliary reference tick, one-cycle enable |
| gen_strobe | output | 6 | One-cycle strobe per generator at the divided rate |
| gen_toggle | output | 6 | Level per generator that inverts on each strobe |

## Verification
The bench reprograms a running divider partway through a period. A design that applies the new code at once would either cut the period short or run its counter past the new limit and go silent. It turns a generator off partway through a count and then back on, which exposes a counter that resumes instead of restarting. It also sends a tick in the cycle right after a write edge and checks that the old setting handles it, and it checks that a ratio of 1 gives a strobe in exactly the next cycle. Vectors that set bit 30 in the legacy layout, and that mix scale values between the two registers, catch a scale bit that is decoded in the wrong layout or for the wrong register.

// File: rtl/fgen_pkg.sv
// Shared constants and types for the frequency generator bank.
// Assumes three generators per 32-bit register and two registers in total.
package fgen_pkg;
    localparam int DATA_W        = 32;
    localparam int NUM_REGS      = 2;
    localparam int GEN_PER_REG   = 3;
    localparam int NUM_GEN       = NUM_REGS * GEN_PER_REG;
    localparam int FIELD_W       = 10;
    localparam int SEL_W         = 2;
    localparam int CODE_W        = FIELD_W - SEL_W;
    localparam int RATIO_W       = CODE_W + 1;
    localparam int SCALE_BIT     = 30;
    localparam int CFG_W         = SCALE_BIT + 1;
    localparam int SRC_COUNT     = 3;

    // Reference tick chosen by a generator; value equals the tick bit index.
    typedef enum logic [1:0] {
        SRC_CPU  = 2'd0,
        SRC_AUX  = 2'd1,
        SRC_AUX2 = 2'd2
    } src_e;

    // Decoded per-generator setting; ratio_m1 is the division ratio minus one.
    typedef struct packed {
        logic                en;
        src_e                src;
        logic [RATIO_W-1:0]  ratio_m1;
    } gen_cfg_t;
endpackage

// File: rtl/fgen_regs.sv
// Configuration register pair with a word-wide read/write port.
// Assumes full-word writes; the copy handed to the generators lags the
// registers by one cycle, and carries only the bits the generators use.
module fgen_regs
    import fgen_pkg::*;
#(
    parameter int REGS   = NUM_REGS,
    parameter int WIDTH  = DATA_W,
    localparam int ADDR_W = (REGS > 1) ? $clog2(REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    output logic [CFG_W-1:0]  cfg_q [REGS]
);
    logic [WIDTH-1:0] regs [REGS];

    // Register file: clear on reset, store the word at the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < REGS; r++) regs[r] <= '0;
        end else if (wr) begin
            regs[addr] <= wdata;
        end
    end

    // Pipeline copy toward the generators (one cycle of write latency).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < REGS; r++) cfg_q[r] <= '0;
        end else begin
            for (int r = 0; r < REGS; r++) cfg_q[r] <= regs[r][CFG_W-1:0];
        end
    end

    // Read path: addressed register, no wait state.
    assign rdata = regs[addr];

    for (genvar r = 0; r < REGS; r++) begin : g_chk
        a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == ADDR_W'(r)) |=> regs[r] == $past(wdata));
    end
endmodule

// File: rtl/fgen_field_decode.sv
// Turns one 10-bit generator field plus its register's scale bit into a
// decoded setting. EXTENDED picks the layout: 0 legacy, 1 extended.
// Assumes the field is already extracted at its bit position.
module fgen_field_decode
    import fgen_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic [FIELD_W-1:0] field,
    input  logic               scale,
    output gen_cfg_t           cfg
);
    logic [SEL_W-1:0]  sel;
    logic [CODE_W-1:0] ncode;
    logic              unit_step;

    assign sel       = field[SEL_W-1:0];
    assign ncode     = field[FIELD_W-1:SEL_W];
    assign unit_step = EXTENDED && scale;

    if (EXTENDED) begin : g_ext
        // Extended decode: code 0 disables, others pick a source.
        always_comb begin
            cfg.en = (sel != '0);
            case (sel)
                2'd1:    cfg.src = SRC_AUX2;
                2'd2:    cfg.src = SRC_CPU;
                2'd3:    cfg.src = SRC_AUX;
                default: cfg.src = SRC_CPU;
            endcase
            cfg.ratio_m1 = unit_step ? {1'b0, ncode} : {ncode, 1'b1};
        end
    end else begin : g_leg
        // Legacy decode: separate enable bit and one-bit source select.
        always_comb begin
            cfg.en       = sel[1];
            cfg.src      = sel[0] ? SRC_AUX : SRC_CPU;
            cfg.ratio_m1 = unit_step ? {1'b0, ncode} : {ncode, 1'b1};
        end
    end
endmodule

// File: rtl/fgen_divider.sv
// One generator: counts ticks of the chosen source and strobes when the
// count reaches ratio-1. Ratio and source are shadowed and reloaded only
// at terminal count (or while idle), so a running period is never cut.
// Assumes ticks are one-cycle enables in the clk domain.
module fgen_divider
    import fgen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  gen_cfg_t             cfg,
    input  logic [SRC_COUNT-1:0] ticks,
    output logic                 strobe,
    output logic                 toggle
);
    logic               run;
    src_e               act_src;
    logic [RATIO_W-1:0] act_m1;
    logic [RATIO_W-1:0] cnt;
    src_e               use_src;
    logic [RATIO_W-1:0] use_m1;
    logic               sel_tick;
    logic               term;

    // Setting in force: shadow while running, live setting on the first cycle.
    assign use_src = run ? act_src : cfg.src;
    assign use_m1  = run ? act_m1  : cfg.ratio_m1;

    // Source mux over the reference ticks.
    always_comb begin
        case (use_src)
            SRC_CPU:  sel_tick = ticks[0];
            SRC_AUX:  sel_tick = ticks[1];
            SRC_AUX2: sel_tick = ticks[2];
            default:  sel_tick = 1'b0;
        endcase
    end

    assign term = sel_tick && (cnt == use_m1);

    // Counter, shadow reload, strobe and toggle generation.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg.en) begin
            run     <= 1'b0;
            cnt     <= '0;
            strobe  <= 1'b0;
            toggle  <= 1'b0;
            act_src <= SRC_CPU;
            act_m1  <= '0;
        end else begin
            run    <= 1'b1;
            strobe <= term;
            if (!run || term) begin
                act_src <= cfg.src;
                act_m1  <= cfg.ratio_m1;
            end
            if (term) begin
                cnt    <= '0;
                toggle <= ~toggle;
            end else if (sel_tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (!strobe && !toggle && cnt == '0));
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= act_m1));
    a_r7_strobe_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(|ticks));
    a_r10_toggle_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg.en) && !strobe) |-> $stable(toggle));
endmodule

// File: rtl/fgen_bank.sv
// Top of the frequency generator bank: register pair, per-generator field
// decode and dividers. EXTENDED selects the field layout at build time.
// Assumes all inputs are synchronous to clk.
module fgen_bank
    import fgen_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_cpu,
    input  logic              tick_aux,
    input  logic              tick_aux2,
    output logic [5:0]        gen_strobe,
    output logic [5:0]        gen_toggle
);
    logic [CFG_W-1:0]     cfg_q [NUM_REGS];
    logic [SRC_COUNT-1:0] ticks;

    assign ticks = {tick_aux2, tick_aux, tick_cpu};

    fgen_regs #(.REGS(NUM_REGS), .WIDTH(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg_q (cfg_q)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        localparam int REG_IDX = g / GEN_PER_REG;
        localparam int LSB     = FIELD_W * (g % GEN_PER_REG);
        gen_cfg_t cfg;

        fgen_field_decode #(.EXTENDED(EXTENDED)) u_dec (
            .field (cfg_q[REG_IDX][LSB +: FIELD_W]),
            .scale (cfg_q[REG_IDX][SCALE_BIT]),
            .cfg   (cfg)
        );

        fgen_divider u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg    (cfg),
            .ticks  (ticks),
            .strobe (gen_strobe[g]),
            .toggle (gen_toggle[g])
        );
    end
endmodule

// File: tb/test_fgen_bank.sv
`timescale 1ns/1ps
module test_fgen_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_e = 1'b0, wr_l = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_e, rdata_l;
    logic        t_cpu = 1'b0, t_aux = 1'b0, t_aux2 = 1'b0;
    logic [5:0]  stb_e, tgl_e, stb_l, tgl_l;
    int          errors = 0;
    int          checks = 0;
    int          cnt_e [6] = '{default: 0};
    int          cnt_l [6] = '{default: 0};
    int          base  [6] = '{default: 0};
    bit          done = 1'b0;

    always #2 clk = ~clk;

    fgen_bank #(.EXTENDED(1'b1)) i_fgen_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_e), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_e), .tick_cpu(t_cpu),
        .tick_aux(t_aux), .tick_aux2(t_aux2), .gen_strobe(stb_e), .gen_toggle(tgl_e));

    fgen_bank #(.EXTENDED(1'b0)) i_fgen_bank_leg (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_l), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_l), .tick_cpu(t_cpu),
        .tick_aux(t_aux), .tick_aux2(t_aux2), .gen_strobe(stb_l), .gen_toggle(tgl_l));

    // Strobe counters, sampled between edges.
    always @(negedge clk) begin
        for (int g = 0; g < 6; g++) begin
            cnt_e[g] <= cnt_e[g] + int'(stb_e[g]);
            cnt_l[g] <= cnt_l[g] + int'(stb_l[g]);
        end
    end

    // Vector: layout, scale bits (bit r = register r), tick mask
    // (bit0 cpu, bit1 aux, bit2 aux2), tick count, per-generator code,
    // divider code and expected strobe count. Arrays are listed gen5..gen0.
    typedef struct packed {
        logic            ext;
        logic [1:0]      scale;
        logic [2:0]      mask;
        logic [7:0]      nticks;
        logic [5:0][1:0] code;
        logic [5:0][7:0] ncode;
        logic [5:0][7:0] expc;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b1, 2'b10, 3'b111, 8'd12, '{2'd3,2'd2,2'd1,2'd0,2'd3,2'd2},
          '{8'd4,8'd2,8'd0,8'd0,8'd1,8'd0}, '{8'd2,8'd4,8'd12,8'd0,8'd3,8'd6}},
        '{1'b1, 2'b10, 3'b001, 8'd12, '{2'd3,2'd2,2'd1,2'd0,2'd3,2'd2},
          '{8'd4,8'd2,8'd0,8'd0,8'd1,8'd0}, '{8'd0,8'd4,8'd0,8'd0,8'd0,8'd6}},
        '{1'b1, 2'b01, 3'b110, 8'd12, '{2'd1,2'd0,2'd2,2'd3,2'd2,2'd1},
          '{8'd0,8'd0,8'd2,8'd5,8'd0,8'd2}, '{8'd6,8'd0,8'd0,8'd2,8'd0,8'd4}},
        '{1'b1, 2'b01, 3'b001, 8'd12, '{2'd1,2'd0,2'd2,2'd3,2'd2,2'd1},
          '{8'd0,8'd0,8'd2,8'd5,8'd0,8'd2}, '{8'd0,8'd0,8'd2,8'd0,8'd12,8'd0}},
        '{1'b0, 2'b10, 3'b001, 8'd12, '{2'd2,2'd3,2'd2,2'd1,2'd3,2'd2},
          '{8'd0,8'd0,8'd2,8'd0,8'd1,8'd0}, '{8'd6,8'd0,8'd2,8'd0,8'd0,8'd6}},
        '{1'b0, 2'b10, 3'b010, 8'd8,  '{2'd2,2'd3,2'd2,2'd1,2'd3,2'd2},
          '{8'd0,8'd0,8'd2,8'd0,8'd1,8'd0}, '{8'd0,8'd4,8'd0,8'd0,8'd2,8'd0}}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input bit ext, input bit a, input logic [31:0] d);
        @(negedge clk); #1;
        if (ext) wr_e = 1'b1; else wr_l = 1'b1;
        addr = a; wdata = d;
        @(negedge clk); #1;
        wr_e = 1'b0; wr_l = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] mask, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            {t_aux2, t_aux, t_cpu} = mask;
            @(negedge clk); #1;
            {t_aux2, t_aux, t_cpu} = 3'b000;
        end
        idle(2);
    endtask

    task automatic snap(input bit ext);
        for (int g = 0; g < 6; g++) base[g] = ext ? cnt_e[g] : cnt_l[g];
    endtask

    function automatic int diff(input bit ext, input int g);
        return (ext ? cnt_e[g] : cnt_l[g]) - base[g];
    endfunction

    function automatic logic [31:0] mkreg(input vec_t v, input int r);
        logic [31:0] x = '0;
        x[30] = v.scale[r];
        for (int k = 0; k < 3; k++)
            x[10*k +: 10] = {v.ncode[3*r+k], v.code[3*r+k]};
        return x;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(4);
        // R1: reset state of both layouts.
        addr = 1'b0; #1;
        chk(rdata_e == 0 && rdata_l == 0, "R1 reg0 reset", int'(rdata_e | rdata_l), 0);
        addr = 1'b1; #1;
        chk(rdata_e == 0 && rdata_l == 0, "R1 reg1 reset", int'(rdata_e | rdata_l), 0);
        chk({stb_e, tgl_e, stb_l, tgl_l} == 0, "R1 outputs low", int'({stb_e, tgl_e, stb_l, tgl_l}), 0);
        rst_n = 1'b1;
        idle(2);
        pulse(3'b111, 2);
        chk(cnt_e[0] + cnt_e[5] + cnt_l[0] + cnt_l[5] == 0, "R1 all off after reset",
            cnt_e[0] + cnt_e[5] + cnt_l[0] + cnt_l[5], 0);

        // R11, R2, R7: gen1 on CPU tick, ratio 1 (scale set, N=0).
        @(negedge clk); #1;
        wr_e = 1'b1; addr = 1'b0; wdata = 32'h4000_0800;
        @(negedge clk); #1;
        wr_e = 1'b0; t_cpu = 1'b1;
        chk(rdata_e == 32'h4000_0800, "R2 read after write", int'(rdata_e), 32'h4000_0800);
        @(negedge clk); #1;
        chk(stb_e == 6'b0, "R11 tick right after write edge ignored", int'(stb_e), 0);
        t_cpu = 1'b1;
        @(negedge clk); #1;
        chk(stb_e == 6'b000010, "R7 ratio one strobe next cycle", int'(stb_e), 2);
        t_cpu = 1'b0;
        @(negedge clk); #1;
        chk(stb_e == 6'b0, "R7 strobe one cycle wide", int'(stb_e), 0);
        addr = 1'b1; #1;
        chk(rdata_e == 0, "R2 other register untouched", int'(rdata_e), 0);

        // Vector walk over layouts, sources, ratios and scale bits.
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            v = VEC[i];
            wr(v.ext, 1'b0, 32'h0);
            wr(v.ext, 1'b1, 32'h0);
            idle(2);
            wr(v.ext, 1'b0, mkreg(v, 0));
            wr(v.ext, 1'b1, mkreg(v, 1));
            idle(2);
            snap(v.ext);
            pulse(v.mask, int'(v.nticks));
            for (int g = 0; g < 6; g++) begin
                chk(diff(v.ext, g) == int'(v.expc[g]),
                    v.ext ? "R3 R5 R6 vector strobe count" : "R3 R4 R6 vector strobe count",
                    diff(v.ext, g), int'(v.expc[g]));
                chk((v.ext ? tgl_e[g] : tgl_l[g]) == v.expc[g][0], "R10 toggle parity",
                    int'(v.ext ? tgl_e[g] : tgl_l[g]), int'(v.expc[g][0]));
            end
        end

        // R9: change ratio 4 -> 2 mid-period on gen0 (CPU tick).
        wr(1'b1, 1'b0, 32'h0);
        wr(1'b1, 1'b1, 32'h0);
        idle(2);
        wr(1'b1, 1'b0, 32'h0000_0006);
        idle(2);
        snap(1'b1);
        pulse(3'b001, 2);
        wr(1'b1, 1'b0, 32'h0000_0002);
        idle(3);
        pulse(3'b001, 1);
        chk(diff(1'b1, 0) == 0, "R9 old period not cut short", diff(1'b1, 0), 0);
        pulse(3'b001, 1);
        chk(diff(1'b1, 0) == 1, "R9 old period completes", diff(1'b1, 0), 1);
        pulse(3'b001, 2);
        chk(diff(1'b1, 0) == 2, "R9 new ratio after terminal count", diff(1'b1, 0), 2);

        // R8: disable mid-count, ticks while off, then restart from zero.
        wr(1'b1, 1'b0, 32'h0);
        idle(2);
        wr(1'b1, 1'b0, 32'h0000_0006);
        idle(2);
        snap(1'b1);
        pulse(3'b001, 3);
        wr(1'b1, 1'b0, 32'h0);
        idle(2);
        pulse(3'b001, 2);
        chk(diff(1'b1, 0) == 0, "R8 no strobe while off", diff(1'b1, 0), 0);
        chk(tgl_e[0] == 1'b0, "R8 toggle low while off", int'(tgl_e[0]), 0);
        wr(1'b1, 1'b0, 32'h0000_0006);
        idle(2);
        pulse(3'b001, 3);
        chk(diff(1'b1, 0) == 0, "R8 count restarted", diff(1'b1, 0), 0);
        pulse(3'b001, 1);
        chk(diff(1'b1, 0) == 1, "R8 full ratio after re-enable", diff(1'b1, 0), 1);
        chk(tgl_e[0] == 1'b1, "R10 toggle after one strobe", int'(tgl_e[0]), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule